// File: doc/BRIEF.md
# Wrapping Accelerator Read Port

This block is a streaming reader for an auxiliary memory. A DSP sees it as a small group of 16-bit registers in the 0xFFxx page. Software programs a 32-bit start address, a 32-bit end address and a 32-bit current pointer, each split into a high half and a low half. It then pulls words by reading one data register. Each such read returns the word at the pointer and advances the pointer by one. When the advanced pointer would lie beyond the end address, the pointer reloads from the start address and an overflow interrupt fires.

The word at the pointer is kept prefetched from a memory with one cycle of read latency, so a data read finishes in the cycle it is issued. Back-to-back data reads can be made every cycle. Any change of the pointer, whether by a software write or by a read, issues the fetch for the new pointer in that same cycle. The overflow appears as a one-cycle pulse and as a sticky flag, which software clears by writing 1.

Top module: `acc_stream_reader`

## Requirements
- R1: After reset the start, end and pointer registers read 0, and both the overflow flag and the pulse are 0.
- R2: The register offsets are decoded from reg_addr_i as follows: start high 0xD4, start low 0xD5, end high 0xD6, end low 0xD7, pointer high 0xD8, pointer low 0xD9, status 0xDC (bit 0 = overflow flag), data 0xDD. A write to a high or low offset replaces only that 16-bit half, and every half reads back what was written.
- R3: A read of the data offset returns, combinationally in the same cycle, the memory word at the current pointer. This holds from the second cycle after reset onward.
- R4: After a data read, the pointer equals its old value plus one when that sum is not greater than the end address. The sum is compared as a 33-bit value, so a pointer of all ones also wraps.
- R5: When the pointer plus one is greater than the end address, a data read reloads the pointer with the start address. The same read sets the overflow flag and drives ovf_pulse_o high for exactly the following cycle.
- R6: The overflow flag stays set until a status write with bit 0 set clears it. A status write with bit 0 clear leaves the flag unchanged.
- R7: A write to either pointer half triggers a refetch, so a data read in the very next cycle returns the word at the new pointer.
- R8: When the start address is greater than the end address, every data read wraps to start and raises the overflow.
- R9: Reads of any offset other than data leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register offset within the 0xFFxx page |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; a read of the data offset has a side effect |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, valid combinationally |
| mem_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | 32 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after mem_en_o |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_pulse_o | output | 1 | One-cycle overflow pulse |

## Verification
Start and end are swept over every pair in a small window, including equal bounds and start above end. Back-to-back data reads walk the pointer through several laps, which separates the plain increment, the wrap and the always-wrap case. Extra patterns place the region across the high/low half boundary and at the top of the 32-bit space, where an uncarried compare would miss the wrap. Writes to the pointer followed at once by a data read show whether the refetch happens, and interleaved non-data reads show whether the pointer moves by mistake.

// File: rtl/acc_stream_pkg.sv
package acc_stream_pkg;
  localparam logic [7:0] OFS_START_HI = 8'hD4;
  localparam logic [7:0] OFS_START_LO = 8'hD5;
  localparam logic [7:0] OFS_END_HI   = 8'hD6;
  localparam logic [7:0] OFS_END_LO   = 8'hD7;
  localparam logic [7:0] OFS_CUR_HI   = 8'hD8;
  localparam logic [7:0] OFS_CUR_LO   = 8'hD9;
  localparam logic [7:0] OFS_STATUS   = 8'hDC;
  localparam logic [7:0] OFS_DATA     = 8'hDD;
endpackage

// File: rtl/acc_ptr_regs.sv
module acc_ptr_regs
  import acc_stream_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int AW = 2 * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [AW-1:0]    start_o,
  output logic [AW-1:0]    end_o,
  output logic [AW-1:0]    cur_o,
  output logic [AW-1:0]    cur_nxt_o,
  output logic             cur_load_o,
  output logic             wrap_o
);
  logic [AW-1:0] start_q, end_q, cur_q;
  logic          adv;
  logic [AW:0]   inc;

  assign adv    = rd_i && (addr_i == OFS_DATA);
  assign inc    = {1'b0, cur_q} + 1'b1;
  // 33-bit compare so an all-ones pointer still wraps
  assign wrap_o = adv && (inc > {1'b0, end_q});

  always_comb begin
    cur_nxt_o  = cur_q;
    cur_load_o = 1'b0;
    if (wr_i && addr_i == OFS_CUR_HI) begin
      cur_nxt_o[AW-1:REG_W] = wdata_i;
      cur_load_o = 1'b1;
    end else if (wr_i && addr_i == OFS_CUR_LO) begin
      cur_nxt_o[REG_W-1:0] = wdata_i;
      cur_load_o = 1'b1;
    end else if (adv) begin
      cur_nxt_o  = wrap_o ? start_q : inc[AW-1:0];
      cur_load_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          OFS_START_HI: start_q[AW-1:REG_W] <= wdata_i;
          OFS_START_LO: start_q[REG_W-1:0]  <= wdata_i;
          OFS_END_HI:   end_q[AW-1:REG_W]   <= wdata_i;
          OFS_END_LO:   end_q[REG_W-1:0]    <= wdata_i;
          default: ;
        endcase
      end
      if (cur_load_o) cur_q <= cur_nxt_o;
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;
  assign cur_o   = cur_q;

  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !wrap_o |=> cur_q == $past(cur_q) + 1'b1);
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && wrap_o |=> cur_q == $past(start_q));
  a_r9_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !adv |=> $stable(cur_q));
endmodule

// File: rtl/acc_prefetch.sv
module acc_prefetch #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] nxt_i,
  input  logic [AW-1:0] cur_i,
  output logic          mem_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] word_o
);
  logic          primed_q, fetch_q;
  logic [DW-1:0] buf_q;

  // fetch the next pointer in the cycle it changes, so the word is ready one cycle later
  assign mem_en_o   = load_i || !primed_q;
  assign mem_addr_o = load_i ? nxt_i : cur_i;
  assign word_o     = fetch_q ? mem_rdata_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      fetch_q  <= 1'b0;
      buf_q    <= '0;
    end else begin
      primed_q <= 1'b1;
      fetch_q  <= mem_en_o;
      if (fetch_q) buf_q <= mem_rdata_i;
    end
  end

  a_r3_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_o && !fetch_q |=> $stable(word_o));
endmodule

// File: rtl/acc_ovf_irq.sv
module acc_ovf_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap_i;
      if (wrap_i)     flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;

  a_r5_pulse_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> flag_q);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !wrap_i |=> !flag_q);
endmodule

// File: rtl/acc_stream_reader.sv
module acc_stream_reader
  import acc_stream_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int AW = 2 * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mem_en_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [REG_W-1:0] mem_rdata_i,
  output logic             ovf_flag_o,
  output logic             ovf_pulse_o
);
  logic [AW-1:0]    start_w, end_w, cur_w, cur_nxt_w;
  logic             cur_load_w, wrap_w, clr_w;
  logic [REG_W-1:0] word_w;

  acc_ptr_regs #(.REG_W(REG_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .rd_i(reg_rd_i), .wdata_i(reg_wdata_i), .start_o(start_w), .end_o(end_w),
    .cur_o(cur_w), .cur_nxt_o(cur_nxt_w), .cur_load_o(cur_load_w), .wrap_o(wrap_w)
  );

  acc_prefetch #(.AW(AW), .DW(REG_W)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cur_load_w), .nxt_i(cur_nxt_w),
    .cur_i(cur_w), .mem_en_o(mem_en_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .word_o(word_w)
  );

  assign clr_w = reg_wr_i && (reg_addr_i == OFS_STATUS) && reg_wdata_i[0];

  acc_ovf_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap_w), .clr_i(clr_w),
    .flag_o(ovf_flag_o), .pulse_o(ovf_pulse_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_START_HI: reg_rdata_o = start_w[AW-1:REG_W];
      OFS_START_LO: reg_rdata_o = start_w[REG_W-1:0];
      OFS_END_HI:   reg_rdata_o = end_w[AW-1:REG_W];
      OFS_END_LO:   reg_rdata_o = end_w[REG_W-1:0];
      OFS_CUR_HI:   reg_rdata_o = cur_w[AW-1:REG_W];
      OFS_CUR_LO:   reg_rdata_o = cur_w[REG_W-1:0];
      OFS_STATUS:   reg_rdata_o[0] = ovf_flag_o;
      OFS_DATA:     reg_rdata_o = word_w;
      default: ;
    endcase
  end

  a_r7_refetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && (reg_addr_i == OFS_CUR_HI || reg_addr_i == OFS_CUR_LO) |-> mem_en_o);
  a_r5_pulse_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |-> $past(reg_rd_i) && $past(reg_addr_i) == OFS_DATA);
endmodule

// File: tb/acc_stream_reader_test.sv
module acc_stream_reader_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        mem_en;
  logic [31:0] mem_addr;
  logic [15:0] mem_q = 16'h0;
  logic        ovf_flag, ovf_pulse;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] m_start = 0, m_end = 0, m_cur = 0;
  logic        m_flag = 0;

  always #2.5 clk = ~clk;

  acc_stream_reader uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_en_o(mem_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_q),
    .ovf_flag_o(ovf_flag), .ovf_pulse_o(ovf_pulse)
  );

  function automatic logic [15:0] fw(input logic [31:0] a);
    return (a[15:0] * 16'd41) ^ a[31:16] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) if (mem_en) mem_q <= fw(mem_addr);

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    case (a)
      8'hD4: m_start[31:16] = d;
      8'hD5: m_start[15:0]  = d;
      8'hD6: m_end[31:16]   = d;
      8'hD7: m_end[15:0]    = d;
      8'hD8: m_cur[31:16]   = d;
      8'hD9: m_cur[15:0]    = d;
      8'hDC: if (d[0]) m_flag = 1'b0;
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic set32(input logic [7:0] hi, input logic [31:0] v);
    wr(hi, v[31:16]);
    wr(hi + 8'd1, v[15:0]);
  endtask

  // one data read checked against the model
  task automatic data_rd(input string req);
    logic [15:0] v;
    logic [32:0] n;
    logic        w;
    logic [15:0] exp;
    exp = fw(m_cur);
    n = {1'b0, m_cur} + 33'd1;
    w = n > {1'b0, m_end};
    m_cur = w ? m_start : n[31:0];
    if (w) m_flag = 1'b1;
    rd_reg(8'hDD, v);
    chk(req, {16'h0, v}, {16'h0, exp});
    chk(w ? "R5 pulse" : "R5 no pulse", {31'h0, ovf_pulse}, {31'h0, w});
    chk("R6 flag", {31'h0, ovf_flag}, {31'h0, m_flag});
  endtask

  task automatic chk_cur(input string req);
    logic [15:0] h, l;
    rd_reg(8'hD8, h);
    rd_reg(8'hD9, l);
    chk(req, {h, l}, m_cur);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    chk("R1 flag", {31'h0, ovf_flag}, 32'h0);
    chk("R1 pulse", {31'h0, ovf_pulse}, 32'h0);
    for (int a = 8'hD4; a <= 8'hD9; a++) begin
      rd_reg(a[7:0], v);
      chk("R1 regs", {16'h0, v}, 32'h0);
    end
    rd_reg(8'hDC, v);
    chk("R1 status", {16'h0, v}, 32'h0);

    // R2 readback of each half
    wr(8'hD4, 16'h1234); wr(8'hD5, 16'hABCD);
    wr(8'hD6, 16'h0F0F); wr(8'hD7, 16'hF0F0);
    wr(8'hD8, 16'h5555); wr(8'hD9, 16'hAAAA);
    wr(8'hD5, 16'h0001);
    for (int a = 8'hD4; a <= 8'hD9; a++) begin
      logic [15:0] e;
      case (a)
        8'hD4: e = m_start[31:16]; 8'hD5: e = m_start[15:0];
        8'hD6: e = m_end[31:16];   8'hD7: e = m_end[15:0];
        8'hD8: e = m_cur[31:16];   default: e = m_cur[15:0];
      endcase
      rd_reg(a[7:0], v);
      chk("R2 readback", {16'h0, v}, {16'h0, e});
    end

    // R3/R4/R5/R8 sweep over small regions
    for (int s = 0; s < 6; s++) begin
      for (int e = 0; e < 6; e++) begin
        set32(8'hD4, s);
        set32(8'hD6, e);
        set32(8'hD8, s);
        wr(8'hDC, 16'h0001);
        chk("R6 cleared", {31'h0, ovf_flag}, 32'h0);
        for (int k = 0; k < 9; k++) data_rd(s > e ? "R8 data" : "R3 data");
        chk_cur("R4 pointer");
      end
    end

    // R6 write of 0 keeps the flag
    wr(8'hDC, 16'h0000);
    rd_reg(8'hDC, v);
    chk("R6 keep", {16'h0, v}, {16'h0, 15'h0, m_flag});
    @(negedge clk);
    chk("R5 one cycle pulse", {31'h0, ovf_pulse}, 32'h0);

    // region across the half boundary
    set32(8'hD4, 32'h0001_FFFE);
    set32(8'hD6, 32'h0002_0001);
    set32(8'hD8, 32'h0001_FFFE);
    for (int k = 0; k < 10; k++) data_rd("R4 carry");
    chk_cur("R4 carry pointer");

    // top of the address space
    set32(8'hD4, 32'h0000_0010);
    set32(8'hD6, 32'hFFFF_FFFF);
    set32(8'hD8, 32'hFFFF_FFFE);
    for (int k = 0; k < 4; k++) data_rd("R4 top");
    chk_cur("R4 top pointer");

    // R7 refetch right after a pointer write
    set32(8'hD4, 32'h0000_0000);
    set32(8'hD6, 32'h0003_0000);
    wr(8'hD9, 16'h0077);
    data_rd("R7 lo refetch");
    wr(8'hD8, 16'h0002);
    data_rd("R7 hi refetch");
    wr(8'hD9, 16'h0100);
    data_rd("R7 lo refetch 2");

    // R9 non-data reads do not move the pointer
    for (int a = 8'hD4; a <= 8'hDC; a++) rd_reg(a[7:0], v);
    chk_cur("R9 pointer");
    data_rd("R9 data");

    summary();
  end
endmodule